// File: doc/BRIEF.md
# Bit-Addressed Alias Window Bridge

This bridge is a bus slave that sits in front of a 32 MiB alias window. Every 32-bit word of that window stands for one bit of a real memory region whose base address is fixed by a parameter. A common setup puts the region at 0x2000_0000 and its alias at 0x2200_0000. Another puts the region at 0x4000_0000 and its alias at 0x4200_0000.

An alias read fetches the target byte, halfword or word from downstream memory. It returns the selected bit as 0 or 1. An alias write does a locked read-modify-write on the target unit that sets or clears only that bit. Software can therefore flip a single bit without any risk from other bus masters.

The upstream port is a simple request/response port. A request is held until a one-cycle ready pulse returns it. The downstream port is a master with the same signals, a lock output and its own ready.

Top module: `bitband_bridge`

## Requirements
- R1: The target byte address is BASE_ADDR ORed with (alias address bits [24:0]) shifted right by 5. Alias address bits [31:25] have no effect.
- R2: Before the downstream access, the target address is aligned down to a multiple of 2 for halfword accesses and to a multiple of 4 for word accesses. Byte accesses are not aligned.
- R3: The bit index depends on the access size (up_size 0 = byte, 1 = halfword, 2 or 3 = word). A byte access uses alias address bits [4:2]. A halfword access uses bits [5:2]. A word access uses bits [6:2].
- R4: A read response carries the selected bit of the fetched unit in bit 0, with bits [31:1] zero. A write response returns all zeros.
- R5: A write sets the selected bit when up_wdata[0] is 1 and clears it when up_wdata[0] is 0. Bits [31:1] of up_wdata are ignored. Every other bit of the unit is written back unchanged.
- R6: Each upstream request becomes one downstream read with the same size. A write request is followed by exactly one downstream write of the whole unit. Both downstream transfers of a write carry dn_lock = 1. A read request carries dn_lock = 0.
- R7: While dn_valid is high and dn_ready is low, the downstream address, size, write flag, data and lock stay stable.
- R8: After reset, up_ready and dn_valid are low. up_ready pulses for one cycle per request, only after the last downstream transfer has completed.
- R9: Downstream data is little-endian and right-justified. The unit at the target address sits in dn_rdata/dn_wdata bits [8*2^size-1:0], and bit index k is data bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request present; held until up_ready |
| up_ready | output | 1 | One-cycle pulse: request done, up_rdata valid |
| up_addr | input | 32 | Alias address |
| up_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | 32 | Write data; only bit 0 is used |
| up_rdata | output | 32 | Read response (0 or 1) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream transfer accepted/completed |
| dn_addr | output | 32 | Target byte address, aligned |
| dn_size | output | 2 | Target access size |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Write-back unit, right-justified |
| dn_rdata | input | 32 | Read unit, right-justified, valid with dn_ready |
| dn_lock | output | 1 | Holds the downstream bus through a read-modify-write |

## Verification
A bad captured bit index or size shows up on the first downstream transfer after the request. It appears as a wrong aligned address, or as a write-back word that differs from the read word in a bit other than the selected one. A bad sequencing state shows up as an unlocked write-back, a missing write-back, or a response pulse before the downstream side has finished. All of these are visible within a few cycles of the request. A bad sampled read bit is caught at the very next response.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
  parameter int          WIN_BITS  = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_valid,
  output logic        up_ready,
  input  logic [31:0] up_addr,
  input  logic [1:0]  up_size,
  input  logic        up_write,
  input  logic [31:0] up_wdata,
  output logic [31:0] up_rdata,
  output logic        dn_valid,
  input  logic        dn_ready,
  output logic [31:0] dn_addr,
  output logic [1:0]  dn_size,
  output logic        dn_write,
  output logic [31:0] dn_wdata,
  input  logic [31:0] dn_rdata,
  output logic        dn_lock
);
  localparam int          SHIFT    = 5;
  localparam logic [31:0] WIN_MASK = (32'd1 << WIN_BITS) - 32'd1;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WB, S_RESP} st_t;

  st_t         state;
  logic [31:0] off, tgt, tgt_al;
  logic [4:0]  bidx;
  logic [31:0] addr_q, rd_q, mask;
  logic [1:0]  size_q;
  logic [4:0]  bit_q;
  logic        wr_q, set_q, hit_q;

  assign off = up_addr & WIN_MASK;
  assign tgt = BASE_ADDR | (off >> SHIFT);

  always_comb begin
    case (up_size)
      2'd0:    begin tgt_al = tgt;                 bidx = {2'b00, up_addr[4:2]}; end
      2'd1:    begin tgt_al = {tgt[31:1], 1'b0};   bidx = {1'b0, up_addr[5:2]};  end
      default: begin tgt_al = {tgt[31:2], 2'b00};  bidx = up_addr[6:2];          end
    endcase
  end

  assign mask = 32'd1 << bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      size_q <= '0;
      bit_q  <= '0;
      wr_q   <= 1'b0;
      set_q  <= 1'b0;
      hit_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (up_valid) begin
          addr_q <= tgt_al;
          size_q <= up_size;
          bit_q  <= bidx;
          wr_q   <= up_write;
          set_q  <= up_wdata[0];
          state  <= S_READ;
        end
        S_READ: if (dn_ready) begin
          rd_q  <= dn_rdata;
          hit_q <= |(dn_rdata & mask);
          state <= wr_q ? S_WB : S_RESP;
        end
        S_WB:    if (dn_ready) state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dn_valid = (state == S_READ) || (state == S_WB);
  assign dn_write = (state == S_WB);
  assign dn_lock  = wr_q && dn_valid;
  assign dn_addr  = addr_q;
  assign dn_size  = size_q;
  assign dn_wdata = set_q ? (rd_q | mask) : (rd_q & ~mask);
  assign up_ready = (state == S_RESP);
  assign up_rdata = {31'd0, hit_q & ~wr_q};
endmodule

module bitband_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        up_ready,
  input logic [31:0] up_rdata,
  input logic        dn_valid,
  input logic        dn_ready,
  input logic [31:0] dn_addr,
  input logic [1:0]  dn_size,
  input logic        dn_write,
  input logic [31:0] dn_wdata,
  input logic [31:0] dn_rdata,
  input logic        dn_lock
);
  logic [31:0] rd_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_seen <= '0;
    else if (dn_valid && dn_ready && !dn_write) rd_seen <= dn_rdata;
  end

  assert_align_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_size == 2'd1) |-> dn_addr[0] == 1'b0);
  assert_align_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_size[1]) |-> dn_addr[1:0] == 2'b00);
  assert_resp_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> up_rdata[31:1] == 31'd0);
  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write) |-> $countones(dn_wdata ^ rd_seen) <= 1);
  assert_locked_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write) |-> dn_lock);
  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_addr) && $stable(dn_size)
      && $stable(dn_write) && $stable(dn_wdata) && $stable(dn_lock));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);
  assert_done_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> !dn_valid);
endmodule

bind bitband_bridge bitband_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .up_ready(up_ready), .up_rdata(up_rdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_size(dn_size),
  .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_lock(dn_lock)
);

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [1:0] up_size = '0;
  logic up_ready, dn_valid, dn_write, dn_lock;
  logic [31:0] up_rdata, dn_addr, dn_wdata;
  logic [1:0] dn_size;
  logic dn_ready = 1'b0;
  logic [31:0] dn_rdata = '0;

  always #2.5 clk = ~clk;

  bitband_bridge #(.BASE_ADDR(BASE)) dut_i (.*);

  int checks = 0, failures = 0, responses = 0, requests = 0;

  typedef struct { logic [31:0] addr; logic [1:0] sz; logic wr; logic lk; logic [31:0] wd; } dn_t;
  dn_t dn_q[$];
  logic [31:0] up_q[$];
  string tag_q[$];

  logic [7:0] mem [int unsigned];
  logic [7:0] ref_mem [int unsigned];

  function automatic logic [7:0] dflt(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] mget(logic [31:0] a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction
  function automatic logic [7:0] rget(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction
  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // downstream memory responder with varying latency
  int wait_cnt = 0, lat = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      dn_ready <= 1'b0; wait_cnt <= 0; lat <= 0;
    end else if (dn_ready) begin
      dn_ready <= 1'b0;
    end else if (dn_valid) begin
      if (wait_cnt >= lat) begin
        logic [31:0] u;
        u = '0;
        for (int i = 0; i < nbytes(dn_size); i++) begin
          u[8*i +: 8] = mget(dn_addr + i);
          if (dn_write) mem[dn_addr + i] = dn_wdata[8*i +: 8];
        end
        dn_rdata <= u;
        dn_ready <= 1'b1;
        wait_cnt <= 0;
        lat <= (lat + 1) % 3;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  // monitor: downstream handshakes and upstream responses
  always @(negedge clk) begin
    if (rst_n && dn_valid && dn_ready) begin
      if (dn_q.size() == 0) check(0, "R6 unexpected downstream transfer", dn_addr, 0);
      else begin
        dn_t e;
        e = dn_q.pop_front();
        check(dn_addr == e.addr, "R1/R2 address", dn_addr, e.addr);
        check(dn_size == e.sz && dn_write == e.wr, "R6 size/write",
              {29'd0, dn_write, dn_size}, {29'd0, e.wr, e.sz});
        check(dn_lock == e.lk, "R6 lock", {31'd0, dn_lock}, {31'd0, e.lk});
        if (e.wr) check(dn_wdata == e.wd, "R5 write-back data", dn_wdata, e.wd);
      end
    end
    if (rst_n && up_ready) begin
      responses++;
      if (up_q.size() == 0) check(0, "R8 unexpected response", up_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = up_q.pop_front();
        t = tag_q.pop_front();
        check(up_rdata == e, t, up_rdata, e);
      end
    end
  end

  // driver: computes expectations from the requirements, then issues the request
  task automatic access(logic [31:0] a, logic [1:0] s, logic wr, logic [31:0] wd, string tag);
    logic [31:0] t, unit, nu;
    logic [4:0] b;
    t = BASE | ((a & 32'h01FF_FFFF) >> 5);
    if (s == 2'd1) t[0] = 1'b0;
    if (s[1]) t[1:0] = 2'b00;
    b = (s == 2'd0) ? {2'b0, a[4:2]} : (s == 2'd1) ? {1'b0, a[5:2]} : a[6:2];
    unit = '0;
    for (int i = 0; i < nbytes(s); i++) unit[8*i +: 8] = rget(t + i);
    dn_q.push_back('{t, s, 1'b0, wr, 32'd0});
    if (wr) begin
      nu = wd[0] ? (unit | (32'd1 << b)) : (unit & ~(32'd1 << b));
      for (int i = 0; i < nbytes(s); i++) ref_mem[t + i] = nu[8*i +: 8];
      dn_q.push_back('{t, s, 1'b1, 1'b1, nu});
      up_q.push_back(32'd0);
    end else up_q.push_back({31'd0, unit[b]});
    tag_q.push_back(tag);
    requests++;
    @(negedge clk);
    up_addr = a; up_size = s; up_write = wr; up_wdata = wd; up_valid = 1'b1;
    do @(negedge clk); while (!up_ready);
    up_valid = 1'b0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!up_ready && !dn_valid, "R8 reset state", {30'd0, up_ready, dn_valid}, 0);
    // R4 reads at different sizes and bit positions
    access(32'h2200_0000, 2'd0, 0, 0, "R4 byte read bit0");
    access(32'h2200_001C, 2'd0, 0, 0, "R4 byte read bit7");
    access(32'h2200_0A3C, 2'd1, 0, 0, "R3 half read bit15");
    access(32'h2200_0E7C, 2'd2, 0, 0, "R3 word read bit31");
    access(32'h2200_0034, 2'd0, 0, 0, "R3 byte index masks bits 6:5");
    // R1 upper alias bits ignored, high offset
    access(32'hFE00_0444, 2'd2, 0, 0, "R1 upper alias bits ignored");
    access(32'h23FF_FFE0, 2'd0, 0, 0, "R1 top of window");
    // R5 writes set and clear, upper wdata ignored
    access(32'h2200_0100, 2'd0, 1, 32'h1, "R4 write response zero");
    access(32'h2200_0100, 2'd0, 0, 0, "R5 set readback");
    access(32'h2200_0108, 2'd0, 1, 32'hFFFF_FFFE, "R5 clear with upper bits set");
    access(32'h2200_0108, 2'd0, 0, 0, "R5 clear readback");
    access(32'h2200_0324, 2'd1, 1, 32'h0000_0001, "R2 half write aligned");
    access(32'h2200_0324, 2'd1, 0, 0, "R9 half readback");
    access(32'h2200_0678, 2'd2, 1, 32'h0, "R2 word write clear bit30");
    access(32'h2200_067C, 2'd3, 1, 32'h1, "R3 size3 as word set bit31");
    access(32'h2200_0678, 2'd2, 0, 0, "R9 word readback bit30");
    access(32'h2200_067C, 2'd2, 0, 0, "R9 word readback bit31");
    repeat (4) @(negedge clk);
    check(responses == requests, "R8 one response per request", responses, requests);
    check(dn_q.size() == 0, "R6 all downstream transfers seen", dn_q.size(), 0);
    foreach (ref_mem[k]) check(mget(k) == ref_mem[k], "R5 memory contents", mget(k), ref_mem[k]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule